// File: doc/BRIEF.md
# Countless Circular Byte Queue

This block is a circular queue with one writer and one reader. It decouples a device side that produces or consumes bytes at irregular moments from an application side that works at its own pace. The queue keeps two indices and no occupancy counter. The write index marks the slot that the next accepted byte goes into. The read index marks the oldest byte still held. The writer is the only side that moves the write index, and the reader is the only side that moves the read index.

Because there is no counter, one storage slot is always left unused. This lets the two indices tell "empty" apart from "full": the queue is empty when the indices are equal, and full when one more write would make them equal. A storage depth of N therefore holds at most N-1 bytes. Both indices wrap modulo the depth, and the depth does not have to be a power of two.

The oldest byte is always presented at the read side, with no request needed, while the queue is not empty. A request that cannot be honoured is dropped silently: a write into a full queue and a read from an empty queue leave the queue unchanged.

Top module: `slot_ring_queue`

## Requirements
- R1: After reset, deq_empty is 1 and enq_full is 0.
- R2: deq_empty is 1 exactly when the number of accepted writes since reset equals the number of accepted reads.
- R3: enq_full is 1 exactly when the queue holds DEPTH-1 entries, so at most DEPTH-1 bytes can be held at once.
- R4: While deq_empty is 0, deq_data shows the oldest byte held, in the same cycle it becomes oldest. Bytes leave in the order in which they were accepted.
- R5: When enq_valid is 1 while enq_full is 1, the write is ignored. The held contents and the full flag do not change.
- R6: When deq_req is 1 while deq_empty is 1, the read is ignored. The queue stays empty, and later writes are delivered unaltered.
- R7: When both requests arrive together on a queue that is neither empty nor full, both take effect in the same cycle and the occupancy does not change. On a full queue only the read takes effect, and on an empty queue only the write takes effect.
- R8: Both indices wrap modulo DEPTH. Order and flags stay correct across any number of passes around the storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset; clears both indices |
| enq_valid | input | 1 | Write request; accepted when enq_full is 0 |
| enq_data | input | WIDTH | Byte to store |
| enq_full | output | 1 | Queue holds DEPTH-1 entries |
| deq_req | input | 1 | Read request; accepted when deq_empty is 0 |
| deq_data | output | WIDTH | Oldest byte held |
| deq_empty | output | 1 | Queue holds no entries |

## Verification
The assertions check the following on every cycle:
- the two flags are never both set;
- a full queue stays full unless a read arrives;
- an empty queue stays empty unless a write arrives;
- an accepted write always clears the empty flag;
- the byte shown at the read side holds still until it is removed;
- a simultaneous read and write leaves a partly filled queue neither empty nor full.

Some properties can only be shown by the bench's scenarios, which compare against an independent model of the contents:
- first-in first-out order;
- the exact point at which DEPTH-1 entries make the queue full;
- that a dropped write does not corrupt the held bytes;
- correct behaviour over many wrap-arounds.

// File: rtl/slot_ring_queue.sv
module slot_ring_queue #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enq_valid,
  input  logic [WIDTH-1:0] enq_data,
  output logic             enq_full,
  input  logic             deq_req,
  output logic [WIDTH-1:0] deq_data,
  output logic             deq_empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [WIDTH-1:0] store [DEPTH];
  logic [AW-1:0]    head_q, tail_q;
  logic [AW-1:0]    head_nx, tail_nx;
  logic             take_in, take_out;

  assign head_nx = (head_q == LAST) ? '0 : head_q + AW'(1);
  assign tail_nx = (tail_q == LAST) ? '0 : tail_q + AW'(1);

  assign deq_empty = (head_q == tail_q);
  assign enq_full  = (tail_nx == head_q);
  assign take_in   = enq_valid && !enq_full;
  assign take_out  = deq_req && !deq_empty;
  assign deq_data  = store[head_q];

  always_ff @(posedge clk) begin
    if (take_in) store[tail_q] <= enq_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tail_q <= '0;
    end else if (take_in) begin
      tail_q <= tail_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
    end else if (take_out) begin
      head_q <= head_nx;
    end
  end
endmodule

// File: rtl/slot_ring_queue_checks.sv
module slot_ring_queue_checks #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enq_valid,
  input logic             enq_full,
  input logic             deq_req,
  input logic [WIDTH-1:0] deq_data,
  input logic             deq_empty
);
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(enq_full && deq_empty)); // R3
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (enq_full && !deq_req) |=> enq_full); // R5
  AST_EMPTY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (deq_empty && !enq_valid) |=> deq_empty); // R6
  AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (deq_empty && enq_valid) |=> !deq_empty); // R2
  AST_HEAD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!deq_empty && !deq_req) |=> (!deq_empty && $stable(deq_data))); // R4
  AST_BOTH_KEEP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (enq_valid && deq_req && !enq_full && !deq_empty) |=> (!enq_full && !deq_empty)); // R7
endmodule

bind slot_ring_queue slot_ring_queue_checks #(.WIDTH(WIDTH)) u_checks (
  .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_full(enq_full),
  .deq_req(deq_req), .deq_data(deq_data), .deq_empty(deq_empty)
);

// File: tb/slot_ring_queue_test.sv
module slot_ring_queue_test;
  localparam int CLK_PERIOD = 10;
  localparam int WIDTH = 8;
  localparam int DEPTH = 6;

  logic clk = 0;
  logic rst_n = 0;
  logic enq_valid = 0;
  logic [WIDTH-1:0] enq_data = '0;
  logic deq_req = 0;
  logic enq_full, deq_empty;
  logic [WIDTH-1:0] deq_data;

  int tests = 0;
  int fails = 0;
  bit done = 0;
  logic [WIDTH-1:0] model [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  slot_ring_queue #(.WIDTH(WIDTH), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_data(enq_data),
    .enq_full(enq_full), .deq_req(deq_req), .deq_data(deq_data), .deq_empty(deq_empty)
  );

  function automatic bit exp_empty();
    return model.size() == 0;
  endfunction

  function automatic bit exp_full();
    return model.size() == DEPTH - 1;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check(deq_empty == exp_empty(), "R2 empty flag", deq_empty, exp_empty());
    check(enq_full == exp_full(), "R3 full flag", enq_full, exp_full());
    if (model.size() != 0)
      check(deq_data == model[0], "R4 head data", deq_data, model[0]);
  endtask

  // One cycle: compare outputs at the falling edge, drive, update the model for the coming rise.
  task automatic step(input bit v, input logic [WIDTH-1:0] d, input bit r);
    bit was_empty, was_full;
    @(negedge clk);
    compare_all();
    enq_valid = v; enq_data = d; deq_req = r;
    was_empty = exp_empty();
    was_full = exp_full();
    if (r && !was_empty) void'(model.pop_front());
    if (v && !was_full) model.push_back(d);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check(deq_empty == 1'b1, "R1 empty after reset", deq_empty, 1);
    check(enq_full == 1'b0, "R1 full after reset", enq_full, 0);
    rst_n = 1;

    // R6: reads on an empty queue are dropped
    step(0, 8'h00, 1);
    step(0, 8'h00, 1);
    step(1, 8'hA5, 1);
    step(0, 8'h00, 0);
    check(deq_data == 8'hA5, "R6 write after empty reads", deq_data, 8'hA5);
    step(0, 8'h00, 1);

    // R3/R5: fill past capacity, extra writes dropped
    for (int i = 0; i < DEPTH + 3; i++) step(1, 8'(8'h10 + i), 0);
    step(0, 8'h00, 0);
    check(enq_full == 1'b1, "R3 full at DEPTH-1", enq_full, 1);
    // R7: both on a full queue, only the read takes effect
    step(1, 8'hEE, 1);
    step(1, 8'hEF, 0);
    // R4/R5: drain and confirm order, no dropped byte present
    for (int i = 0; i < DEPTH + 1; i++) step(0, 8'h00, 1);
    check(deq_empty == 1'b1, "R5 drained after overfill", deq_empty, 1);

    // R7: simultaneous on a partly filled queue
    step(1, 8'h31, 0);
    step(1, 8'h32, 0);
    for (int i = 0; i < 10; i++) step(1, 8'(8'h40 + i), 1);
    step(0, 8'h00, 0);
    check(!deq_empty && !enq_full, "R7 level kept", {deq_empty, enq_full}, 0);

    // R8: random traffic, many wraps
    for (int i = 0; i < 3000; i++) begin
      int p = (i / 500) % 3;
      bit v = ($urandom % 4) < (p == 0 ? 3 : (p == 1 ? 1 : 2));
      bit r = ($urandom % 4) < (p == 0 ? 1 : (p == 1 ? 3 : 2));
      step(v, 8'($urandom), r);
    end
    for (int i = 0; i < DEPTH; i++) step(0, 8'h00, 1);
    step(0, 8'h00, 0);
    check(deq_empty == 1'b1, "R8 empty after wraps", deq_empty, 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule